// File: doc/BRIEF.md
# Serial Port Host Register File with Interrupt Identification

This block is the processor-facing register set of a byte-wide asynchronous serial port. A host reaches eight byte locations through a 3-bit offset with separate read and write strobes. The top bit of the line control byte switches offsets 0 and 1 between two banks. With the bit clear, they reach the data path and the interrupt enables. With the bit set, they reach the two bytes of the 16-bit baud divisor. The divisor and the line control value are brought out to the bit-level serializer, and so is the transmit holding byte, through a load/take handshake. Received bytes arrive on a one-cycle valid strobe.

Four interrupt causes are tracked: a line error, received data waiting, the transmit holding register draining, and a change on the modem inputs. Each cause has its own enable bit. The enabled causes are priority-encoded into an identification field that always names the most urgent one. Reads of particular registers clear the cause they report, so the host can service one cause after another by reading the identification register again.

The transmit holding register is tracked by a two-state machine. `THR_EMPTY` moves to `THR_FULL` when the host writes the holding byte. `THR_FULL` stays in `THR_FULL` when the host writes again, which overwrites the byte. `THR_FULL` moves back to `THR_EMPTY` when the serializer takes the byte and no write occurs in the same cycle. That last transition raises the holding-empty cause.

Top module: `uart_regfile`

## Requirements
- R1: After reset the line control byte, divisor and enables are zero, the holding register is empty, offset 2 reads 0x01, offset 5 reads 0x20 and `irq` is low.
- R2: Offset 3 is a read/write line control byte, and its bit 7 selects the divisor bank at offsets 0 and 1.
- R3: With bit 7 set, offset 0 reads and writes the low divisor byte and offset 1 the high byte, and `divisor` shows both on the clock after the write. The holding register and the enables are untouched.
- R4: With bit 7 clear, a write to offset 0 sets `tx_full` and `tx_data` on the next clock. `tx_take` while full, with no write in the same cycle, clears `tx_full` on the next clock.
- R5: `rx_valid` captures `rx_data` and sets data-ready. A read of offset 0 (bit 7 clear) returns the byte and clears data-ready. `rx_valid` while data-ready is set, with no read of offset 0 in that cycle, sets overrun.
- R6: Offset 1 (bit 7 clear) holds the enables in bits 3..0: bit 0 received data, bit 1 holding empty, bit 2 line error, bit 3 modem change. Bits 7..4 read 0.
- R7: Offset 2 reads {4'b0, id[2:0], none}. Among the enabled pending causes the priority is line error (id 3'b011), then received data (3'b010), then holding empty (3'b001), then modem change (3'b000). With nothing pending it reads 0x01.
- R8: `irq` is high exactly when at least one enabled cause is pending.
- R9: The holding-empty cause is set by the `THR_FULL` to `THR_EMPTY` transition. It is cleared by a read of offset 2 that reports it, or by a write of the holding register.
- R10: Offset 5 reads bit 0 data-ready, bit 1 overrun, bit 3 framing error (set by `line_err`) and bit 5 holding empty. A read clears overrun and the framing error, and with them the line error cause.
- R11: Offset 6 reads {modem_lines, delta[3:0]}, where each delta bit latches a change on its line. Any delta bit is the modem cause, and a read of offset 6 clears all delta bits.
- R12: Writes to offsets 2, 4, 5, 6 and 7 have no effect, and reads of offsets 4 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects at the clock edge) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| rx_valid | input | 1 | Serializer delivers a received byte |
| rx_data | input | 8 | Received byte |
| line_err | input | 1 | Framing error event from the receiver |
| tx_take | input | 1 | Serializer takes the holding byte |
| modem_lines | input | 4 | Modem input lines |
| tx_full | output | 1 | Holding register holds a byte |
| tx_data | output | 8 | Holding byte |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control byte |
| irq | output | 1 | Interrupt request |

## Verification
Each cause is first raised alone, which shows that it maps to its own identification code and enable bit. The causes are then stacked, with all four pending together, and the identification register is read after each clear. This tells the priority order apart from any order that merely follows arrival. Masked runs, with the enables at zero and the same events, separate the pending state from the request output. The bank-switch runs write the same offsets with bit 7 set and with it clear, which shows that divisor writes leave the holding register and enables alone. Writes to read-only offsets are followed by reads that show nothing moved.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int CAUSE_N = 4;

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_ID   = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LCTL = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_LSTS = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_MSTS = 3'd6;

    localparam logic [2:0] ID_LINE  = 3'b011;
    localparam logic [2:0] ID_RXDAT = 3'b010;
    localparam logic [2:0] ID_TXEMP = 3'b001;
    localparam logic [2:0] ID_MODEM = 3'b000;

    typedef enum logic {THR_EMPTY = 1'b0, THR_FULL = 1'b1} thr_state_t;
endpackage

// File: rtl/uart_thr_fsm.sv
module uart_thr_fsm
    import uart_regfile_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data,
    output logic         drained
);
    thr_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            THR_EMPTY: if (load) state_nx = THR_FULL;
            THR_FULL:  if (take && !load) state_nx = THR_EMPTY;
            default:   state_nx = THR_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= THR_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data <= '0;
        else if (load) data <= load_data;
    end

    always_comb begin
        full    = (state == THR_FULL);
        drained = (state == THR_FULL) && (state_nx == THR_EMPTY);
    end

    assert_load_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full);
    assert_take_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && full && !load) |=> !full);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_regfile_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_N-1:0] act,     // [3] line, [2] rx data, [1] tx empty, [0] modem
    output logic [2:0]         id,
    output logic               none
);
    logic [CAUSE_N-1:0] grant;

    always_comb begin
        grant = '0;
        id    = ID_MODEM;
        none  = 1'b1;
        if (act[3]) begin
            grant[3] = 1'b1; id = ID_LINE;  none = 1'b0;
        end else if (act[2]) begin
            grant[2] = 1'b1; id = ID_RXDAT; none = 1'b0;
        end else if (act[1]) begin
            grant[1] = 1'b1; id = ID_TXEMP; none = 1'b0;
        end else if (act[0]) begin
            grant[0] = 1'b1; id = ID_MODEM; none = 1'b0;
        end
    end

    assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_line_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        act[3] |-> (id == ID_LINE && !none));
    assert_idle_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> none);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_regfile_pkg::*;
#(
    parameter int MODEM_W = 4,
    localparam int DIV_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              line_err,
    input  logic              tx_take,
    input  logic [MODEM_W-1:0] modem_lines,
    output logic              tx_full,
    output logic [DATA_W-1:0] tx_data,
    output logic [DIV_W-1:0]  divisor,
    output logic [DATA_W-1:0] line_ctrl,
    output logic              irq
);
    logic [DATA_W-1:0]  div_lo, div_hi, rbr;
    logic [CAUSE_N-1:0] ien;
    logic               dr, oe, fe;
    logic [MODEM_W-1:0] lines_q, delta;
    logic               thre_pend, drained;
    logic [2:0]         id;
    logic               none;
    logic               dlab;

    assign dlab = line_ctrl[DATA_W-1];

    // strobes
    logic wr_data, wr_dlo, wr_dhi, wr_ien, wr_lctl;
    logic rd_rbr, rd_id, rd_lsts, rd_msts, clr_thre;
    always_comb begin
        wr_data = wr_en && addr == OFS_DATA && !dlab;
        wr_dlo  = wr_en && addr == OFS_DATA &&  dlab;
        wr_ien  = wr_en && addr == OFS_IEN  && !dlab;
        wr_dhi  = wr_en && addr == OFS_IEN  &&  dlab;
        wr_lctl = wr_en && addr == OFS_LCTL;
        rd_rbr  = rd_en && addr == OFS_DATA && !dlab;
        rd_id   = rd_en && addr == OFS_ID;
        rd_lsts = rd_en && addr == OFS_LSTS;
        rd_msts = rd_en && addr == OFS_MSTS;
        clr_thre = rd_id && !none && id == ID_TXEMP;
    end

    uart_thr_fsm #(.W(DATA_W)) u_thr (
        .clk(clk), .rst_n(rst_n), .load(wr_data), .load_data(wdata),
        .take(tx_take), .full(tx_full), .data(tx_data), .drained(drained)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_ctrl <= '0;
            div_lo    <= '0;
            div_hi    <= '0;
            ien       <= '0;
        end else begin
            if (wr_lctl) line_ctrl <= wdata;
            if (wr_dlo)  div_lo    <= wdata;
            if (wr_dhi)  div_hi    <= wdata;
            if (wr_ien)  ien       <= wdata[CAUSE_N-1:0];
        end
    end
    assign divisor = {div_hi, div_lo};

    // status and pending causes; a set in the same cycle wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbr       <= '0;
            dr        <= 1'b0;
            oe        <= 1'b0;
            fe        <= 1'b0;
            thre_pend <= 1'b0;
            lines_q   <= '0;
            delta     <= '0;
        end else begin
            if (rx_valid) rbr <= rx_data;
            dr        <= rx_valid | (dr & ~rd_rbr);
            oe        <= (rx_valid & dr & ~rd_rbr) | (oe & ~rd_lsts);
            fe        <= line_err | (fe & ~rd_lsts);
            thre_pend <= drained | (thre_pend & ~(wr_data | clr_thre));
            lines_q   <= modem_lines;
            delta     <= (modem_lines ^ lines_q) | (delta & {MODEM_W{~rd_msts}});
        end
    end

    logic [CAUSE_N-1:0] act;
    always_comb begin
        act[3] = (oe | fe)    & ien[2];
        act[2] = dr           & ien[0];
        act[1] = thre_pend    & ien[1];
        act[0] = (|delta)     & ien[3];
    end

    uart_irq_prio u_prio (
        .clk(clk), .rst_n(rst_n), .act(act), .id(id), .none(none)
    );
    assign irq = ~none;

    always_comb begin
        rdata = '0;
        unique case (addr)
            3'd0:    rdata = dlab ? div_lo : rbr;
            3'd1:    rdata = dlab ? div_hi : {{(DATA_W-CAUSE_N){1'b0}}, ien};
            3'd2:    rdata = {{(DATA_W-4){1'b0}}, id, none};
            3'd3:    rdata = line_ctrl;
            3'd5:    rdata = {2'b00, ~tx_full, 1'b0, fe, 1'b0, oe, dr};
            3'd6:    rdata = {modem_lines, delta};
            default: rdata = '0;
        endcase
    end

    assert_rx_sets_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rdata_dr_view());
    assert_div_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dlo |=> (divisor[DATA_W-1:0] == $past(wdata)));
    assert_lsr_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsts && !line_err && !(rx_valid && dr && !rd_rbr)) |=> !(oe || fe));
    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
    assert_drain_pends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_take && !wr_en) |=> thre_pend);

    function automatic logic rdata_dr_view();
        return dr;
    endfunction
endmodule

// File: tb/uart_regfile_test.sv
`timescale 1ns/100ps
module uart_regfile_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 0, rd_en = 0, rx_valid = 0, line_err = 0, tx_take = 0;
    logic [7:0] wdata = '0, rx_data = '0;
    logic [3:0] modem_lines = '0;
    logic [7:0] rdata, tx_data, line_ctrl;
    logic [15:0] divisor;
    logic       tx_full, irq;

    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    uart_regfile uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .line_err(line_err), .tx_take(tx_take), .modem_lines(modem_lines),
        .tx_full(tx_full), .tx_data(tx_data), .divisor(divisor),
        .line_ctrl(line_ctrl), .irq(irq)
    );

    // behavioural reference state
    logic [7:0] m_lcr, m_dll, m_dlm, m_thr, m_rbr;
    logic [3:0] m_ier, m_delta, m_prev;
    logic       m_full, m_dr, m_oe, m_fe, m_thre;

    function automatic logic [7:0] m_iir();
        if ((m_oe || m_fe) && m_ier[2]) return 8'h06;
        if (m_dr && m_ier[0])           return 8'h04;
        if (m_thre && m_ier[1])         return 8'h02;
        if ((m_delta != 0) && m_ier[3]) return 8'h00;
        return 8'h01;
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_lcr[7] ? m_dll : m_rbr;
            3'd1: return m_lcr[7] ? m_dlm : {4'h0, m_ier};
            3'd2: return m_iir();
            3'd3: return m_lcr;
            3'd5: return {2'b00, !m_full, 1'b0, m_fe, 1'b0, m_oe, m_dr};
            3'd6: return {modem_lines, m_delta};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return m_lcr[7] ? "R3" : "R5";
            3'd1: return m_lcr[7] ? "R3" : "R6";
            3'd2: return (m_iir() == 8'h02) ? "R9" : "R7";
            3'd3: return "R2";
            3'd5: return "R10";
            3'd6: return "R11";
            default: return "R12";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lcr = 0; m_dll = 0; m_dlm = 0; m_thr = 0; m_rbr = 0;
            m_ier = 0; m_delta = 0; m_prev = 0;
            m_full = 0; m_dr = 0; m_oe = 0; m_fe = 0; m_thre = 0;
        end else begin
            bit dl, w0, rrb, clr_t, drain;
            dl    = m_lcr[7];
            w0    = wr_en && addr == 0 && !dl;
            rrb   = rd_en && addr == 0 && !dl;
            clr_t = rd_en && addr == 2 && m_iir() == 8'h02;
            drain = m_full && tx_take && !w0;
            m_thre = drain || (m_thre && !(w0 || clr_t));
            if (w0) begin m_thr = wdata; m_full = 1; end
            else if (tx_take) m_full = 0;
            m_oe = (rx_valid && m_dr && !rrb) || (m_oe && !(rd_en && addr == 5));
            m_fe = line_err || (m_fe && !(rd_en && addr == 5));
            m_dr = rx_valid || (m_dr && !rrb);
            if (rx_valid) m_rbr = rx_data;
            m_delta = (modem_lines ^ m_prev) | ((rd_en && addr == 6) ? 4'h0 : m_delta);
            m_prev = modem_lines;
            if (wr_en && addr == 0 && dl) m_dll = wdata;
            if (wr_en && addr == 1 && dl) m_dlm = wdata;
            if (wr_en && addr == 1 && !dl) m_ier = wdata[3:0];
            if (wr_en && addr == 3) m_lcr = wdata;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // compare on every clock, after inputs settle and before the edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk(tag_of(addr), {8'h0, rdata}, {8'h0, m_read(addr)});
            chk("R8", {15'h0, irq}, {15'h0, m_iir() != 8'h01});
            chk("R4", {15'h0, tx_full}, {15'h0, m_full});
            chk("R4", {8'h0, tx_data}, {8'h0, m_thr});
            chk("R3", divisor, {m_dlm, m_dll});
            chk("R2", {8'h0, line_ctrl}, {8'h0, m_lcr});
        end
    end

    task automatic quiet();
        wr_en = 0; rd_en = 0; rx_valid = 0; line_err = 0; tx_take = 0;
    endtask
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); quiet(); addr = a; wr_en = 1; wdata = d;
    endtask
    task automatic rd(input logic [2:0] a);
        @(negedge clk); quiet(); addr = a; rd_en = 1;
    endtask
    task automatic ev(input logic rv, input logic [7:0] rd_b, input logic le, input logic tk);
        @(negedge clk); quiet(); rx_valid = rv; rx_data = rd_b; line_err = le; tx_take = tk;
    endtask
    task automatic idle();
        @(negedge clk); quiet();
    endtask
    task automatic rd_expect(input logic [2:0] a, input logic [7:0] e, input string tag);
        rd(a); #1; chk(tag, {8'h0, rdata}, {8'h0, e});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        rd_expect(3'd2, 8'h01, "R1");
        chk("R1", {15'h0, irq}, 16'h0);
        rd_expect(3'd5, 8'h20, "R1");
        chk("R1", divisor, 16'h0);
        chk("R1", {8'h0, line_ctrl}, 16'h0);

        // R2/R3 divisor bank
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        idle(); #1; chk("R3", divisor, 16'h1234);
        chk("R3", {15'h0, tx_full}, 16'h0);
        rd_expect(3'd0, 8'h34, "R3");
        rd_expect(3'd1, 8'h12, "R3");
        wr(3'd3, 8'h1B);
        rd_expect(3'd1, 8'h00, "R6");   // enables untouched by divisor writes
        wr(3'd1, 8'hFF);
        rd_expect(3'd1, 8'h0F, "R6");

        // R4/R9 holding register
        wr(3'd0, 8'h55);
        idle(); #1; chk("R4", {8'h0, tx_data}, 16'h0055);
        ev(0, 8'h00, 0, 1);
        idle(); #1; chk("R9", {15'h0, irq}, 16'h1);
        rd_expect(3'd2, 8'h02, "R9");
        rd_expect(3'd2, 8'h01, "R9");
        wr(3'd0, 8'h66); ev(0, 8'h00, 0, 1);
        wr(3'd0, 8'h77);                  // R9: holding write clears the cause
        rd_expect(3'd2, 8'h01, "R9");
        ev(0, 8'h00, 0, 1);

        // R5/R10 receive path and overrun
        ev(1, 8'hA5, 0, 0);
        rd_expect(3'd2, 8'h04, "R7");
        ev(1, 8'h5A, 0, 0);
        rd_expect(3'd2, 8'h06, "R7");
        rd_expect(3'd5, 8'h23, "R10");
        rd_expect(3'd2, 8'h04, "R10");
        rd_expect(3'd0, 8'h5A, "R5");
        rd_expect(3'd2, 8'h02, "R7");
        rd(3'd2);

        // R11 modem change
        @(negedge clk); quiet(); modem_lines = 4'b0101;
        idle(); rd_expect(3'd2, 8'h00, "R11");
        rd_expect(3'd6, 8'h55, "R11");
        rd_expect(3'd2, 8'h01, "R11");

        // R7 all four causes at once, serviced in priority order
        @(negedge clk); quiet(); rx_valid = 1; rx_data = 8'hC3; line_err = 1; modem_lines = 4'b1111;
        wr(3'd0, 8'h11); ev(0, 8'h00, 0, 1);
        rd_expect(3'd2, 8'h06, "R7");
        rd(3'd5);
        rd_expect(3'd2, 8'h04, "R7");
        rd(3'd0);
        rd_expect(3'd2, 8'h02, "R7");
        rd_expect(3'd2, 8'h00, "R7");
        rd(3'd6);
        rd_expect(3'd2, 8'h01, "R7");

        // R8 masked causes keep irq low
        wr(3'd1, 8'h00);
        ev(1, 8'h42, 1, 0);
        idle(); #1; chk("R8", {15'h0, irq}, 16'h0);
        rd_expect(3'd2, 8'h01, "R8");
        wr(3'd1, 8'h01);
        idle(); #1; chk("R8", {15'h0, irq}, 16'h1);

        // R12 writes to read-only and unused offsets do nothing
        wr(3'd2, 8'hFF); wr(3'd5, 8'h00); wr(3'd6, 8'hFF); wr(3'd4, 8'hAA); wr(3'd7, 8'hBB);
        rd_expect(3'd4, 8'h00, "R12");
        rd_expect(3'd7, 8'h00, "R12");
        rd_expect(3'd5, 8'h29, "R12");
        rd_expect(3'd6, 8'hF0, "R12");
        idle(); idle();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule